// File: doc/BRIEF.md
# Interrupt Register Bank

This block is the 32-bit memory-mapped register front end of a small device. It decodes single-word accesses in a one-megabyte window and answers reads one cycle later. It holds an identification word that never changes and a scratch register that stores the complement of each value written to it. It also keeps an interrupt status word that drives one level-sensitive interrupt line.

Software raises interrupts by OR-writing bits into the status word. It acknowledges them by writing a mask of the bits to clear. Internal datapaths, such as a DMA engine that reports completion, reach the block through an event side port, and each event sets its own status bit. Accesses of a size other than a full word are filtered out. The interrupt line stays high until the whole status word has been cleared.

Top module: `irq_regfile`

## Requirements
- R1: The access size is given as a byte count on `req_size`, and only the value 4 is honoured. A read of any other size returns 0xFFFFFFFF, and a write of any other size changes no register and leaves the line unchanged.
- R2: A word read of offset 0x00 returns 0x010000ED, and writes to that offset have no effect.
- R3: A word write to offset 0x04 stores the bitwise complement of the write data, and a word read of 0x04 returns the stored value.
- R4: A word read of offset 0x24 returns the interrupt status word as it stood before the edge at which the read is accepted.
- R5: A word write to offset 0x60 ORs the data into the status word and drives `irq` high from the next cycle, even when the data is zero.
- R6: A word write to offset 0x64 clears each status bit that is 1 in the data. `irq` goes low only after such a write leaves the status word at zero, and `irq` is never low while any status bit is set.
- R7: An event pulse on `evt_done[i]` sets status bit 8+i and drives `irq` high from the next cycle.
- R8: A word read of any offset other than 0x00, 0x04 and 0x24 returns zero.
- R9: When an event and a clear write hit the same status bit in one cycle, the bit ends up set and `irq` stays high.
- R10: Reset, which is synchronous and active high, clears the status word, the scratch register, `irq` and `rsp_valid`.
- R11: `rsp_valid` is high in exactly the cycle after each accepted read, and it stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W (20) | Byte offset in the register window |
| req_size | input | 3 | Access size in bytes (only 4 is honoured) |
| req_wdata | input | DATA_W (32) | Write data |
| evt_done | input | NUM_EVT (1) | Completion pulses from internal datapaths |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W (32) | Read data |
| irq | output | 1 | Level interrupt line |

## Verification
Two functions can act on the status word in the same cycle: an internal completion event and a software clear-write. The bench provokes this by driving an `evt_done` pulse in the same cycle as a write to 0x64 whose mask covers bit 8, both directed and at random during a long mixed sequence. It judges the outcome by reading 0x24 afterwards and by watching `irq` on every clock, against a behavioural model in which the set is applied after the clear. The same model also covers a raise-write of zero, where the line rises while the status word is empty, and the zero-mask clear that later drops it.

// File: rtl/irq_regfile_pkg.sv
package irq_regfile_pkg;

  // Offsets whose meaning software depends on
  localparam logic [31:0] OFS_IDENT  = 32'h0000_0000;
  localparam logic [31:0] OFS_SCRAT  = 32'h0000_0004;
  localparam logic [31:0] OFS_STATUS = 32'h0000_0024;
  localparam logic [31:0] OFS_RAISE  = 32'h0000_0060;
  localparam logic [31:0] OFS_ACK    = 32'h0000_0064;

  localparam logic [31:0] IDENT_WORD = 32'h0100_00ED;
  localparam logic [2:0]  SIZE_WORD  = 3'd4;

  // One-hot register selection produced by the decoder
  typedef struct packed {
    logic ident;
    logic scrat;
    logic status;
    logic raise;
    logic ack;
  } reg_sel_t;

endpackage

// File: rtl/irq_regfile_dec.sv
module irq_regfile_dec
  import irq_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic              word_ok,
  output reg_sel_t          sel
);

  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFS_IDENT);
  localparam logic [ADDR_W-1:0] A_SCRAT  = ADDR_W'(OFS_SCRAT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_RAISE  = ADDR_W'(OFS_RAISE);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);

  always_comb begin
    word_ok    = (size == SIZE_WORD);
    sel        = '0;
    sel.ident  = (addr == A_IDENT);
    sel.scrat  = (addr == A_SCRAT);
    sel.status = (addr == A_STATUS);
    sel.raise  = (addr == A_RAISE);
    sel.ack    = (addr == A_ACK);
  end

endmodule

// File: rtl/irq_regfile_scratch.sv
module irq_regfile_scratch #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] scr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_q <= '0;
    end else if (wr_en) begin
      scr_q <= ~wdata;
    end
  end

endmodule

// File: rtl/irq_regfile_stat.sv
module irq_regfile_stat #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EVT_BASE = 8,
  parameter int unsigned NUM_EVT  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raise_en,
  input  logic               ack_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_EVT-1:0] evt,
  output logic [DATA_W-1:0]  stat_q,
  output logic               irq_q
);

  logic [DATA_W-1:0] evt_mask;
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] stat_nxt;
  logic              irq_nxt;
  logic              any_evt;

  // Place each event on its own status bit
  always_comb begin
    evt_mask = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      evt_mask[EVT_BASE+i] = evt[i];
    end
  end

  always_comb begin
    any_evt  = |evt;
    set_mask = raise_en ? wdata : '0;
    clr_mask = ack_en   ? wdata : '0;
    // Clear first, then sets: a same-cycle set survives a clear
    stat_nxt = (stat_q & ~clr_mask) | set_mask | evt_mask;
    if (raise_en || any_evt) begin
      irq_nxt = 1'b1;
    end else if (ack_en && (stat_nxt == '0)) begin
      irq_nxt = 1'b0;
    end else begin
      irq_nxt = irq_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      irq_q  <= irq_nxt;
    end
  end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EVT_BASE = 8,
  parameter int unsigned NUM_EVT  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [2:0]         req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [NUM_EVT-1:0] evt_done,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               irq
);

  localparam logic [DATA_W-1:0] IDENT_VAL = DATA_W'(IDENT_WORD);

  logic              word_ok;
  reg_sel_t          sel;
  logic              wr_ok;
  logic              rd_req;
  logic [DATA_W-1:0] scr_q;
  logic [DATA_W-1:0] stat_q;
  logic              irq_q;
  logic [DATA_W-1:0] rd_mux;

  irq_regfile_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (req_addr),
    .size    (req_size),
    .word_ok (word_ok),
    .sel     (sel)
  );

  assign wr_ok  = req_valid & req_write & word_ok;
  assign rd_req = req_valid & ~req_write;

  irq_regfile_scratch #(.DATA_W(DATA_W)) u_scr (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_ok & sel.scrat),
    .wdata (req_wdata),
    .scr_q (scr_q)
  );

  irq_regfile_stat #(
    .DATA_W   (DATA_W),
    .EVT_BASE (EVT_BASE),
    .NUM_EVT  (NUM_EVT)
  ) u_stat (
    .clk      (clk),
    .rst      (rst),
    .raise_en (wr_ok & sel.raise),
    .ack_en   (wr_ok & sel.ack),
    .wdata    (req_wdata),
    .evt      (evt_done),
    .stat_q   (stat_q),
    .irq_q    (irq_q)
  );

  always_comb begin
    if (!word_ok) begin
      rd_mux = '1;
    end else if (sel.ident) begin
      rd_mux = IDENT_VAL;
    end else if (sel.scrat) begin
      rd_mux = scr_q;
    end else if (sel.status) begin
      rd_mux = stat_q;
    end else begin
      rd_mux = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_mux : '0;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/irq_regfile_chk.sv
module irq_regfile_chk
  import irq_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EVT_BASE = 8,
  parameter int unsigned NUM_EVT  = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [2:0]         req_size,
  input logic [DATA_W-1:0]  req_wdata,
  input logic [NUM_EVT-1:0] evt_done,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               irq,
  input logic [DATA_W-1:0]  stat_q,
  input logic [DATA_W-1:0]  scr_q
);

  logic wr_word;
  logic rd_req;
  assign wr_word = req_valid && req_write && (req_size == SIZE_WORD);
  assign rd_req  = req_valid && !req_write;

  p_size_filter_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_size != SIZE_WORD) |=> (rsp_rdata == '1));

  p_ident_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_size == SIZE_WORD && req_addr == ADDR_W'(OFS_IDENT))
      |=> (rsp_rdata == DATA_W'(IDENT_WORD)));

  p_scratch_inv_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_word && req_addr == ADDR_W'(OFS_SCRAT)) |=> (scr_q == ~$past(req_wdata)));

  p_raise_line_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_word && req_addr == ADDR_W'(OFS_RAISE)) |=> irq);

  p_low_empty_r6: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (stat_q == '0));

  p_drop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> (stat_q == '0));

  p_event_set_r7: assert property (@(posedge clk) disable iff (rst)
    evt_done[0] |=> (irq && stat_q[EVT_BASE]));

  p_rsp_read_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq && stat_q == '0 && scr_q == '0 && !rsp_valid));

endmodule

bind irq_regfile irq_regfile_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .EVT_BASE (EVT_BASE),
  .NUM_EVT  (NUM_EVT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .req_wdata (req_wdata),
  .evt_done  (evt_done),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .stat_q    (stat_q),
  .scr_q     (scr_q)
);

// File: tb/irq_regfile_tb_top.sv
module irq_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr  = '0;
  logic [2:0]  req_size  = 3'd4;
  logic [31:0] req_wdata = '0;
  logic [0:0]  evt_done  = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  always #5 clk = ~clk;

  irq_regfile dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .evt_done  (evt_done),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Behavioural reference state
  logic [31:0] m_stat = '0;
  logic [31:0] m_scr  = '0;
  bit          m_irq  = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit w, logic [19:0] a, logic [2:0] s,
                      logic [31:0] d, bit e);
    logic [31:0] exp_rd;
    logic [31:0] set_m;
    logic [31:0] clr_m;
    bit exp_rv;
    bit raise;
    bit ack;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_size = s;
    req_wdata = d; evt_done = e;
    exp_rv = v && !w;
    exp_rd = '0;
    if (exp_rv) begin
      if (s != 3'd4) exp_rd = 32'hFFFF_FFFF;
      else if (a == 20'h0)  exp_rd = 32'h0100_00ED;
      else if (a == 20'h4)  exp_rd = m_scr;
      else if (a == 20'h24) exp_rd = m_stat;
      else exp_rd = '0;
    end
    set_m = '0; clr_m = '0; raise = 0; ack = 0;
    if (v && w && s == 3'd4) begin
      if (a == 20'h4) m_scr = ~d;
      if (a == 20'h60) begin set_m = d; raise = 1; end
      if (a == 20'h64) begin clr_m = d; ack = 1; end
    end
    m_stat = (m_stat & ~clr_m) | set_m | (e ? 32'h0000_0100 : 32'h0);
    if (raise || e) m_irq = 1'b1;
    else if (ack && m_stat == 32'h0) m_irq = 1'b0;
    @(posedge clk);
    #1;
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    check({tag, " rsp_valid R11"}, {31'b0, rsp_valid}, {31'b0, exp_rv});
    if (exp_rv) check({tag, " rdata"}, rsp_rdata, exp_rd);
  endtask

  task automatic rd(string tag, logic [19:0] a);
    step(tag, 1, 0, a, 3'd4, 32'h0, 0);
  endtask

  task automatic wr(string tag, logic [19:0] a, logic [31:0] d);
    step(tag, 1, 1, a, 3'd4, d, 0);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 20'h0, 3'd4, 32'h0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 irq in reset", {31'b0, irq}, 32'h0);
    check("R10 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    rd("R10 status after reset", 20'h24);
    rd("R10 scratch after reset", 20'h4);

    // Identification and size filtering
    rd("R2 ident", 20'h0);
    wr("R2 write ident", 20'h0, 32'h1234_5678);
    rd("R2 ident after write", 20'h0);
    step("R1 half read", 1, 0, 20'h0, 3'd2, 32'h0, 0);
    step("R1 byte read", 1, 0, 20'h24, 3'd1, 32'h0, 0);

    // Scratch
    wr("R3 scratch write", 20'h4, 32'h1234_5678);
    rd("R3 scratch read", 20'h4);
    step("R1 half scratch write", 1, 1, 20'h4, 3'd2, 32'hAAAA_5555, 0);
    rd("R1 scratch unchanged", 20'h4);
    wr("R3 scratch zero", 20'h4, 32'h0);
    rd("R3 scratch ones", 20'h4);

    // Raise of zero, zero clear
    wr("R5 raise zero", 20'h60, 32'h0);
    rd("R5 status empty", 20'h24);
    wr("R6 clear zero drops", 20'h64, 32'h0);

    // Raise and partial acknowledge
    wr("R5 raise bits", 20'h60, 32'h0000_0005);
    rd("R4 status read", 20'h24);
    step("R1 byte ack ignored", 1, 1, 20'h64, 3'd1, 32'hFFFF_FFFF, 0);
    rd("R4 status kept", 20'h24);
    wr("R6 partial ack", 20'h64, 32'h0000_0001);
    idle("R6 line held");
    wr("R6 final ack", 20'h64, 32'h0000_0004);
    rd("R4 status zero", 20'h24);

    // Internal event
    step("R7 event", 0, 0, 20'h0, 3'd4, 32'h0, 1);
    rd("R7 status bit", 20'h24);
    // Event against a clear of the same bit
    step("R9 event vs clear", 1, 1, 20'h64, 3'd4, 32'h0000_0100, 1);
    rd("R9 bit kept", 20'h24);
    // Event together with a read of status
    step("R4 read during event", 1, 0, 20'h24, 3'd4, 32'h0, 1);
    wr("R6 clear event", 20'h64, 32'h0000_0100);

    // Unmapped reads
    rd("R8 unmapped 0x10", 20'h10);
    rd("R8 raise reads zero", 20'h60);
    rd("R8 high offset", 20'hF_FF00);

    // Mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [19:0] a;
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = 20'h0;
        1: a = 20'h4;
        2: a = 20'h24;
        3: a = 20'h60;
        4: a = 20'h64;
        default: a = 20'h10;
      endcase
      step("R9 mixed", $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
           ($urandom_range(0, 5) == 0) ? 3'd2 : 3'd4,
           ($urandom_range(0, 1) == 1) ? $urandom : ($urandom & 32'h0000_0107),
           $urandom_range(0, 5) == 0);
    end

    // Reset mid-operation
    wr("R5 raise before reset", 20'h60, 32'h0000_0F00);
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    evt_done = 1'b0;
    @(posedge clk);
    #1;
    check("R10 irq cleared", {31'b0, irq}, 32'h0);
    m_stat = '0; m_scr = '0; m_irq = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    rd("R10 status cleared", 20'h24);
    rd("R10 scratch cleared", 20'h4);
    finish_run();
  end

endmodule